// File: doc/BRIEF.md
# Fuse-Map Kernel Stream Filter

This block parses an ASCII fuse-map transfer sent in kernel mode, one byte per accepted handshake on a valid/ready input. It waits for the start-of-text byte and skips the free-text design specification up to its closing '*'. It then reads letter-tagged fields that each end in '*'. Only fuse-list fields reach the output. Every other field type is consumed and dropped.

A fuse-list field carries a decimal start address followed by fuse bits. Each bit comes out as a single-cycle write strobe with its address and value, and the address then steps by one. At the end-of-text byte the block discards a fixed-length transmission checksum without checking it and pulses a frame-done flag. The security fuse output is held at zero. A sticky flag records malformed fuse lists.

Top module: `kfs_kernel_filter`

## Requirements
- R1: Out of reset, fuse_we, frame_done, fmt_err and sec_fuse are 0 and in_ready is 1.
- R2: Bytes received before a start-of-text byte (0x02) produce no write strobe.
- R3: After 0x02, every byte up to and including the first '*' (0x2A) is design text and produces no write strobe, even if it looks like a fuse list.
- R4: A field whose first character is anything other than 'L' (0x4C), end-of-text (0x03) or whitespace is consumed up to its '*' and dropped. This covers C, F, G, Q, V and X fields.
- R5: In a field starting with 'L', decimal digits (0x30-0x39) up to the first whitespace form the start address. Each following '0'/'1' byte gives one cycle of fuse_we, with fuse_addr equal to the current address and fuse_bit equal to the bit. The address then increments. The outputs appear in the cycle after the byte is accepted.
- R6: Space (0x20), CR (0x0D) and LF (0x0A) inside a fuse list are skipped and do not advance the address.
- R7: When 0x03 arrives at a field boundary, the next 4 accepted bytes are discarded without any check. frame_done is high for exactly one cycle after the 4th byte is accepted, and the block then waits for a new 0x02.
- R8: sec_fuse is always 0.
- R9: An unexpected character in place of an address digit or fuse bit sets fmt_err, which stays set until reset. The rest of that field is dropped.
- R10: A byte is consumed only in a cycle where in_valid is high; while in_valid is low no strobe is produced and the parse state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | ASCII input byte |
| in_ready | output | 1 | Block can accept a byte |
| fuse_we | output | 1 | One-cycle fuse write strobe |
| fuse_addr | output | ADDR_W | Address of the written fuse |
| fuse_bit | output | 1 | Value of the written fuse |
| sec_fuse | output | 1 | Security fuse, always zero |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| fmt_err | output | 1 | Sticky fuse-list format error |

## Verification
The stimulus places '0' and '1' characters where a careless parser would take them as fuse bits: before start-of-text, inside the design text, inside a dropped test-vector field and in the checksum. A design that leaked any of them would raise fuse_we. Line breaks and spaces appear between fuse bits, so a design that advanced the address on whitespace would report shifted addresses. A second fuse list starting at a lower address would expose a design that failed to clear the address between fields. The bench also checks that frame_done stays low on the third checksum byte and fires on the fourth, catching an off-by-one counter. It checks that a bad character sets fmt_err, that the flag survives the rest of the frame, and that stalled input does not produce writes.

// File: rtl/kfs_pkg.sv
package kfs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPEC,
    ST_FIELD,
    ST_SKIP,
    ST_ADDR,
    ST_BITS,
    ST_CSUM
  } kfs_state_e;

  localparam logic [7:0] CH_STX  = 8'h02;
  localparam logic [7:0] CH_ETX  = 8'h03;
  localparam logic [7:0] CH_STAR = 8'h2A;
  localparam logic [7:0] CH_L    = 8'h4C;
endpackage

// File: rtl/kfs_char_class.sv
module kfs_char_class (
  input  logic [7:0] ch,
  output logic       is_digit,
  output logic       is_bit,
  output logic       is_ws,
  output logic       is_star
);
  always_comb begin
    is_digit = (ch >= 8'h30) && (ch <= 8'h39);
    is_bit   = (ch == 8'h30) || (ch == 8'h31);
    is_ws    = (ch == 8'h20) || (ch == 8'h0D) || (ch == 8'h0A);
    is_star  = (ch == kfs_pkg::CH_STAR);
  end
endmodule

// File: rtl/kfs_addr_acc.sv
module kfs_addr_acc #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift_en,
  input  logic [3:0]        digit,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] times_ten;

  // decimal shift-in: addr*10 + digit, truncated to ADDR_W
  always_comb times_ten = (addr << 3) + (addr << 1) + ADDR_W'(digit);

  always_ff @(posedge clk) begin
    if (rst || clear)  addr <= '0;
    else if (shift_en) addr <= times_ten;
    else if (inc)      addr <= addr + 1'b1;
  end
endmodule

// File: rtl/kfs_csum_cnt.sv
module kfs_csum_cnt #(
  parameter int CSUM_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic last
);
  localparam int CW = $clog2(CSUM_LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || start) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  assign last = tick && (cnt == CW'(CSUM_LEN - 1));
endmodule

// File: rtl/kfs_kernel_filter.sv
module kfs_kernel_filter #(
  parameter int ADDR_W   = 16,
  parameter int CSUM_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              fuse_we,
  output logic [ADDR_W-1:0] fuse_addr,
  output logic              fuse_bit,
  output logic              sec_fuse,
  output logic              frame_done,
  output logic              fmt_err
);
  import kfs_pkg::*;

  kfs_state_e        state;
  logic              ready_q;
  logic              accept;
  logic              is_digit, is_bit, is_ws, is_star;
  logic              acc_clear, acc_shift, acc_inc;
  logic              cs_start, cs_tick, cs_last;
  logic [ADDR_W-1:0] acc_addr;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;
  assign sec_fuse = 1'b0;

  kfs_char_class u_class (
    .ch       (in_data),
    .is_digit (is_digit),
    .is_bit   (is_bit),
    .is_ws    (is_ws),
    .is_star  (is_star)
  );

  always_comb begin
    acc_clear = accept && (state == ST_FIELD) && (in_data == CH_L);
    acc_shift = accept && (state == ST_ADDR) && is_digit;
    acc_inc   = accept && (state == ST_BITS) && is_bit;
    cs_start  = accept && (state == ST_FIELD) && (in_data == CH_ETX);
    cs_tick   = accept && (state == ST_CSUM);
  end

  kfs_addr_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clear    (acc_clear),
    .shift_en (acc_shift),
    .digit    (in_data[3:0]),
    .inc      (acc_inc),
    .addr     (acc_addr)
  );

  kfs_csum_cnt #(.CSUM_LEN(CSUM_LEN)) u_csum (
    .clk   (clk),
    .rst   (rst),
    .start (cs_start),
    .tick  (cs_tick),
    .last  (cs_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ready_q    <= 1'b0;
      fuse_we    <= 1'b0;
      fuse_addr  <= '0;
      fuse_bit   <= 1'b0;
      frame_done <= 1'b0;
      fmt_err    <= 1'b0;
    end else begin
      ready_q    <= 1'b1;
      fuse_we    <= 1'b0;
      frame_done <= 1'b0;
      if (accept) begin
        unique case (state)
          ST_IDLE:  if (in_data == CH_STX) state <= ST_SPEC;
          ST_SPEC:  if (is_star) state <= ST_FIELD;
          ST_FIELD: begin
            if (in_data == CH_ETX)     state <= ST_CSUM;
            else if (in_data == CH_L)  state <= ST_ADDR;
            else if (!is_ws)           state <= ST_SKIP;
          end
          ST_SKIP:  if (is_star) state <= ST_FIELD;
          ST_ADDR: begin
            if (is_star)       state <= ST_FIELD;
            else if (is_ws)    state <= ST_BITS;
            else if (!is_digit) begin
              fmt_err <= 1'b1;
              state   <= ST_SKIP;
            end
          end
          ST_BITS: begin
            if (is_bit) begin
              fuse_we   <= 1'b1;
              fuse_addr <= acc_addr;
              fuse_bit  <= in_data[0];
            end else if (is_star) begin
              state <= ST_FIELD;
            end else if (!is_ws) begin
              fmt_err <= 1'b1;
              state   <= ST_SKIP;
            end
          end
          ST_CSUM: if (cs_last) begin
            frame_done <= 1'b1;
            state      <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err);                                            // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);                                     // R7
  AST_WE_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fuse_we && frame_done));                                       // R7
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    fuse_we |-> $past(in_valid));                                    // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fuse_we && $past(fuse_we)) |-> (fuse_addr == $past(fuse_addr) + 1'b1)); // R5
endmodule

// File: tb/kfs_kernel_filter_tb.sv
module kfs_kernel_filter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NVEC       = 31;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = 8'h00;
  logic              in_ready, fuse_we, fuse_bit, sec_fuse, frame_done, fmt_err;
  logic [ADDR_W-1:0] fuse_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kfs_kernel_filter #(.ADDR_W(ADDR_W), .CSUM_LEN(4)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fuse_we(fuse_we), .fuse_addr(fuse_addr),
    .fuse_bit(fuse_bit), .sec_fuse(sec_fuse), .frame_done(frame_done),
    .fmt_err(fmt_err)
  );

  // {byte, exp_we, exp_addr, exp_bit, exp_done}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h02, 1'b0, 16'd0,  1'b0, 1'b0},
    {"L",   1'b0, 16'd0,  1'b0, 1'b0},
    {"0",   1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b0, 16'd0,  1'b0, 1'b0},
    {"*",   1'b0, 16'd0,  1'b0, 1'b0},
    {"V",   1'b0, 16'd0,  1'b0, 1'b0},
    {"0",   1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b0, 16'd0,  1'b0, 1'b0},
    {"*",   1'b0, 16'd0,  1'b0, 1'b0},
    {"L",   1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b0, 16'd0,  1'b0, 1'b0},
    {"2",   1'b0, 16'd0,  1'b0, 1'b0},
    {" ",   1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b1, 16'd12, 1'b1, 1'b0},
    {"0",   1'b1, 16'd13, 1'b0, 1'b0},
    {8'h0D, 1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b1, 16'd14, 1'b1, 1'b0},
    {"*",   1'b0, 16'd0,  1'b0, 1'b0},
    {"G",   1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b0, 16'd0,  1'b0, 1'b0},
    {"*",   1'b0, 16'd0,  1'b0, 1'b0},
    {"L",   1'b0, 16'd0,  1'b0, 1'b0},
    {"7",   1'b0, 16'd0,  1'b0, 1'b0},
    {" ",   1'b0, 16'd0,  1'b0, 1'b0},
    {"0",   1'b1, 16'd7,  1'b0, 1'b0},
    {"*",   1'b0, 16'd0,  1'b0, 1'b0},
    {8'h03, 1'b0, 16'd0,  1'b0, 1'b0},
    {"1",   1'b0, 16'd0,  1'b0, 1'b0},
    {"2",   1'b0, 16'd0,  1'b0, 1'b0},
    {"3",   1'b0, 16'd0,  1'b0, 1'b0},
    {"4",   1'b0, 16'd0,  1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs of the edge between
  task automatic send(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: got %0h expected %0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 / R8 reset state
    chk(fuse_we == 1'b0,    "R1", fuse_we, 0);
    chk(frame_done == 1'b0, "R1", frame_done, 0);
    chk(fmt_err == 1'b0,    "R1", fmt_err, 0);
    chk(in_ready == 1'b1,   "R1", in_ready, 1);
    chk(sec_fuse == 1'b0,   "R8", sec_fuse, 0);

    // main frame table
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0]        b;
      logic              ew, eb, ed;
      logic [ADDR_W-1:0] ea;
      string             tag;
      {b, ew, ea, eb, ed} = VEC[i];
      tag = ew ? "R5" : (ed ? "R7" : "R3/R4/R6");
      send(b);
      chk(fuse_we == ew,    tag, fuse_we, ew);
      chk(frame_done == ed, tag, frame_done, ed);
      chk(sec_fuse == 1'b0, "R8", sec_fuse, 0);
      if (ew) begin
        chk(fuse_addr == ea, "R5", fuse_addr, ea);
        chk(fuse_bit == eb,  "R5", fuse_bit, eb);
      end
    end
    chk(fmt_err == 1'b0, "R9", fmt_err, 0);

    // R2: no start-of-text yet, fuse-like bytes must not write
    send("1"); chk(fuse_we == 1'b0, "R2", fuse_we, 0);
    send("L"); send("0"); send(" ");
    send("1"); chk(fuse_we == 1'b0, "R2", fuse_we, 0);
    send("0"); chk(fuse_we == 1'b0, "R2", fuse_we, 0);

    // R10: stalled input holds state and writes nothing
    send(8'h02); send("*"); send("L"); send("3"); send(" ");
    in_data = "1";
    in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fuse_we == 1'b0, "R10", fuse_we, 0);
    end
    send("1");
    chk(fuse_we == 1'b1 && fuse_addr == 16'd3, "R10", {fuse_we, fuse_addr}, {1'b1, 16'd3});

    // R9: bad character where a bit is expected
    send("x");
    chk(fmt_err == 1'b1, "R9", fmt_err, 1);
    send("1");
    chk(fuse_we == 1'b0, "R9", fuse_we, 0);
    send("*"); send(8'h03); send("a"); send("b");
    send("c"); chk(frame_done == 1'b0, "R7", frame_done, 0);
    send("d"); chk(frame_done == 1'b1, "R7", frame_done, 1);
    @(negedge clk);
    chk(frame_done == 1'b0, "R7", frame_done, 0);
    chk(fmt_err == 1'b1, "R9", fmt_err, 1);
    do_reset();
    chk(fmt_err == 1'b0, "R1", fmt_err, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule